// File: doc/BRIEF.md
# ISA DMA Bus-Hold Arbiter

This block sits in a PCI-to-ISA bridge. It takes DMA requests from ISA channels and turns them into a bus-hold request toward the system arbiter. When hold is granted, it issues a DMA acknowledge to exactly one channel. In parallel it follows a delayed PCI-to-ISA transaction through its phases.

The hold request follows the OR of the channel requests combinationally, whatever the state of any delayed transaction. The acknowledge is where the two concerns meet. It is withheld while the delayed transaction still owns the ISA bus, and while the ISA bus is busy for any other reason. Once the transaction's ISA cycle has ended, the acknowledge may be issued, even though the PCI master has not yet finished its retry. The phase tracker keeps following the three transaction events at all times, including while a DMA master owns the bus.

Top module: `isa_hold_arb`

## Requirements
- R1: A synchronous active-high reset sets `dt_phase` to 2'b00 and drives every bit of `dack_n` high. With no request active, `hold_n` is high.
- R2: `dt_phase` moves from 2'b00 to 2'b10 on `dt_isa_start`, from 2'b10 to 2'b11 on `dt_isa_end`, and from 2'b11 back to 2'b00 on `dt_retry_done`. Each move is seen after the clock edge at which the event is high. An event that arrives outside the phase it belongs to is ignored.
- R3: `hold_n` is low in the same cycle that any bit of `dreq` is high, and high in the same cycle that all bits are low. The phase has no effect on it.
- R4: While `dt_phase` is 2'b10, no acknowledge is newly asserted, even with `hold_ack_n` low.
- R5: When `hold_ack_n` is low, a request is active, no channel is acknowledged, `isa_busy` is low and the phase is 2'b00 or 2'b11, the chosen channel's `dack_n` bit goes low after that clock edge.
- R6: While `isa_busy` is high, no acknowledge is newly asserted.
- R7: The channel granted is the lowest-numbered one with its `dreq` bit high at the grant edge. At most one `dack_n` bit is ever low.
- R8: A granted acknowledge stays low until that channel's `dreq` bit drops, even if a higher-priority request appears. It goes high after the first clock edge at which the request is seen low.
- R9: `dt_retry_done` returns phase 2'b11 to 2'b00 even while a DMA acknowledge is asserted.
- R10: No acknowledge is asserted while `hold_ack_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dreq | input | NCH | DMA request per channel, active high |
| hold_ack_n | input | 1 | Hold acknowledge from the system arbiter, active low |
| isa_busy | input | 1 | ISA bus busy with some other cycle |
| dt_isa_start | input | 1 | Pulse: the delayed transaction's ISA cycle begins |
| dt_isa_end | input | 1 | Pulse: the delayed transaction's ISA cycle ends |
| dt_retry_done | input | 1 | Pulse: the PCI master's retry has completed |
| hold_n | output | 1 | Bus-hold request to the system arbiter, active low |
| dack_n | output | NCH | DMA acknowledge per channel, active low |
| dt_phase | output | 2 | Delayed-transaction phase: 00 idle, 10 ISA cycle running, 11 waiting for retry |

## Verification
The bench holds hold-acknowledge low across the end of the ISA cycle. A design that looked at the next phase instead of the current one would grant one cycle early, while the bus was still busy. It raises a lower-numbered request while another channel holds the acknowledge. A design that re-arbitrated every cycle would switch channels and cause a bus conflict. It completes the PCI retry during DMA ownership; a tracker frozen by DMA ownership would stay stuck in the retry phase. It also sends each phase event into the wrong phase, where a design that did not guard its transitions would jump phases.

// File: rtl/isa_hold_pkg.sv
package isa_hold_pkg;
  // Delayed-transaction phase; the codes are visible on dt_phase.
  typedef enum logic [1:0] {
    PH_IDLE  = 2'b00,
    PH_ISA   = 2'b10,
    PH_RETRY = 2'b11
  } dt_phase_e;

  // Next phase for a set of event pulses; out-of-phase events are dropped.
  function automatic dt_phase_e phase_step(input dt_phase_e cur, input logic ev_start,
                                           input logic ev_end, input logic ev_done);
    dt_phase_e nxt;
    nxt = cur;
    case (cur)
      PH_IDLE:  if (ev_start) nxt = PH_ISA;
      PH_ISA:   if (ev_end)   nxt = PH_RETRY;
      PH_RETRY: if (ev_done)  nxt = PH_IDLE;
      default:  nxt = PH_IDLE;
    endcase
    return nxt;
  endfunction

  // The ISA bus may be handed to a DMA master only when neither the
  // delayed transaction nor another cycle occupies it.
  function automatic logic isa_free(input dt_phase_e cur, input logic other_busy);
    return (cur != PH_ISA) && !other_busy;
  endfunction
endpackage

// File: rtl/isa_dt_phase.sv
module isa_dt_phase
  import isa_hold_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ev_start,
  input  logic      ev_end,
  input  logic      ev_done,
  output dt_phase_e phase
);
  dt_phase_e phase_q;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_IDLE;
    else     phase_q <= phase_step(phase_q, ev_start, ev_end, ev_done);
  end

  assign phase = phase_q;
endmodule

// File: rtl/isa_dma_grant.sv
module isa_dma_grant #(
  parameter int NCH = 4,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] req,
  input  logic           hlda_n,
  input  logic           bus_free,
  output logic [NCH-1:0] ack_n,
  output logic           grant_fire,
  output logic           release_fire
);
  logic          owned_q;
  logic [CW-1:0] owner_q;
  logic [CW-1:0] pick;

  // Fixed priority: scanning downward leaves the lowest set index.
  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (req[i]) pick = CW'(i);
  end

  assign grant_fire   = !owned_q && !hlda_n && (|req) && bus_free;
  assign release_fire = owned_q && !req[owner_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      owned_q <= 1'b0;
      owner_q <= '0;
    end else if (release_fire) begin
      owned_q <= 1'b0;
    end else if (grant_fire) begin
      owned_q <= 1'b1;
      owner_q <= pick;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ack
    assign ack_n[g] = !(owned_q && (owner_q == CW'(g)));
  end
endmodule

// File: rtl/isa_hold_arb.sv
module isa_hold_arb
  import isa_hold_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] dreq,
  input  logic           hold_ack_n,
  input  logic           isa_busy,
  input  logic           dt_isa_start,
  input  logic           dt_isa_end,
  input  logic           dt_retry_done,
  output logic           hold_n,
  output logic [NCH-1:0] dack_n,
  output logic [1:0]     dt_phase
);
  dt_phase_e phase;
  logic      bus_free;
  logic      grant_fire;
  logic      release_fire;

  isa_dt_phase u_phase (
    .clk      (clk),
    .rst      (rst),
    .ev_start (dt_isa_start),
    .ev_end   (dt_isa_end),
    .ev_done  (dt_retry_done),
    .phase    (phase)
  );

  assign bus_free = isa_free(phase, isa_busy);

  isa_dma_grant #(.NCH(NCH)) u_grant (
    .clk          (clk),
    .rst          (rst),
    .req          (dreq),
    .hlda_n       (hold_ack_n),
    .bus_free     (bus_free),
    .ack_n        (dack_n),
    .grant_fire   (grant_fire),
    .release_fire (release_fire)
  );

  // The hold request ignores any pending delayed transaction.
  assign hold_n   = ~(|dreq);
  assign dt_phase = phase;
endmodule

// File: rtl/isa_hold_arb_chk.sv
module isa_hold_arb_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] dreq,
  input logic           hold_ack_n,
  input logic           isa_busy,
  input logic           dt_isa_end,
  input logic           dt_retry_done,
  input logic           hold_n,
  input logic [NCH-1:0] dack_n,
  input logic [1:0]     dt_phase,
  input logic           grant_fire,
  input logic           release_fire
);
  assert_hold_follows_req_R3: assert property (@(posedge clk) disable iff (rst)
    (|dreq) == !hold_n);

  assert_phase_legal_R2: assert property (@(posedge clk) disable iff (rst)
    dt_phase != 2'b01);

  assert_isa_phase_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (dt_phase == 2'b10 && !dt_isa_end) |=> dt_phase == 2'b10);

  assert_retry_done_leaves_R9: assert property (@(posedge clk) disable iff (rst)
    (dt_phase == 2'b11 && dt_retry_done) |=> dt_phase == 2'b00);

  assert_no_ack_in_isa_phase_R4: assert property (@(posedge clk) disable iff (rst)
    (dt_phase == 2'b10 && (&dack_n)) |=> (&dack_n));

  assert_no_ack_when_busy_R6: assert property (@(posedge clk) disable iff (rst)
    (isa_busy && (&dack_n)) |=> (&dack_n));

  assert_single_ack_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~dack_n));

  assert_ack_kept_R8: assert property (@(posedge clk) disable iff (rst)
    (!(&dack_n) && ((dreq & ~dack_n) != '0)) |=> $stable(dack_n));

  assert_release_R8: assert property (@(posedge clk) disable iff (rst)
    release_fire |=> (&dack_n));

  assert_grant_visible_R5: assert property (@(posedge clk) disable iff (rst)
    grant_fire |=> !(&dack_n));

  assert_no_ack_without_hlda_R10: assert property (@(posedge clk) disable iff (rst)
    (hold_ack_n && (&dack_n)) |=> (&dack_n));
endmodule

bind isa_hold_arb isa_hold_arb_chk #(.NCH(NCH)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .dreq          (dreq),
  .hold_ack_n    (hold_ack_n),
  .isa_busy      (isa_busy),
  .dt_isa_end    (dt_isa_end),
  .dt_retry_done (dt_retry_done),
  .hold_n        (hold_n),
  .dack_n        (dack_n),
  .dt_phase      (dt_phase),
  .grant_fire    (grant_fire),
  .release_fire  (release_fire)
);

// File: tb/isa_hold_arb_test.sv
module isa_hold_arb_test;
  localparam int NCH = 4;
  localparam int NV  = 19;
  // Fields: dreq[15:12] hlda_n[11] busy[10] start[9] end[8] done[7]
  //         exp_hold_n[6] exp_dack_n[5:2] exp_phase[1:0]
  localparam logic [15:0] VEC [NV] = '{
    16'b0000_1_0_000_1_1111_00, // 0  R3 idle
    16'b0000_1_0_100_1_1111_10, // 1  R2 start
    16'b0100_1_0_000_0_1111_10, // 2  R3 hold while pending
    16'b0100_0_0_000_0_1111_10, // 3  R4 deferred in ISA phase
    16'b0100_0_0_010_0_1111_11, // 4  R4 end edge still deferred
    16'b0100_0_0_000_0_1011_11, // 5  R5 grant in retry phase
    16'b0101_0_0_001_0_1011_00, // 6  R8 kept, R9 done while owned
    16'b0001_0_0_000_0_1111_00, // 7  R8 release
    16'b0001_0_0_000_0_1110_00, // 8  R5 grant idle
    16'b0000_0_0_000_1_1111_00, // 9  R3/R8 drop
    16'b0000_1_0_000_1_1111_00, // 10
    16'b1010_1_0_000_0_1111_00, // 11 R10 no hlda
    16'b1010_0_1_000_0_1111_00, // 12 R6 busy
    16'b1010_0_0_000_0_1101_00, // 13 R7 lowest wins
    16'b1000_0_0_000_0_1111_00, // 14 R8 release
    16'b1000_0_0_000_0_0111_00, // 15 R7 channel 3
    16'b0000_1_0_000_1_1111_00, // 16
    16'b0000_1_0_010_1_1111_00, // 17 R2 end ignored in idle
    16'b0000_1_0_001_1_1111_00  // 18 R2 done ignored in idle
  };
  localparam int VREQ [NV] = '{3,2,3,4,4,5,8,8,5,3,3,10,6,7,8,7,3,2,2};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] dreq = '0;
  logic hold_ack_n = 1'b1, isa_busy = 1'b0;
  logic dt_isa_start = 1'b0, dt_isa_end = 1'b0, dt_retry_done = 1'b0;
  logic hold_n;
  logic [NCH-1:0] dack_n;
  logic [1:0] dt_phase;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  isa_hold_arb #(.NCH(NCH)) uut (
    .clk(clk), .rst(rst), .dreq(dreq), .hold_ack_n(hold_ack_n), .isa_busy(isa_busy),
    .dt_isa_start(dt_isa_start), .dt_isa_end(dt_isa_end), .dt_retry_done(dt_retry_done),
    .hold_n(hold_n), .dack_n(dack_n), .dt_phase(dt_phase)
  );

  task automatic check(input string req, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] r, input logic h, input logic b,
                       input logic s, input logic e, input logic d);
    @(negedge clk);
    dreq = r; hold_ack_n = h; isa_busy = b;
    dt_isa_start = s; dt_isa_end = e; dt_retry_done = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1", "phase", {6'b0, dt_phase}, 8'h00);
    check("R1", "dack_n", {4'b0, dack_n}, 8'h0F);
    check("R1", "hold_n", {7'b0, hold_n}, 8'h01);

    for (int v = 0; v < NV; v++) begin
      logic [15:0] w;
      string tag;
      w = VEC[v];
      tag = $sformatf("R%0d", VREQ[v]);
      drive(w[15:12], w[11], w[10], w[9], w[8], w[7]);
      #1;
      check("R3", $sformatf("hold_n v%0d", v), {7'b0, hold_n}, {7'b0, w[6]});
      @(negedge clk);
      check(tag, $sformatf("dack_n v%0d", v), {4'b0, dack_n}, {4'b0, w[5:2]});
      check(tag, $sformatf("phase v%0d", v), {6'b0, dt_phase}, {6'b0, w[1:0]});
    end

    // R2: out-of-phase events are ignored in the ISA and retry phases
    drive(4'b0000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    drive(4'b0000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1); // start and done inside ISA phase
    @(negedge clk);
    check("R2", "ISA phase kept", {6'b0, dt_phase}, 8'h02);
    dt_isa_start = 1'b0; dt_retry_done = 1'b0; dt_isa_end = 1'b1;
    drive(4'b0000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0); // start and end inside retry phase
    @(negedge clk);
    check("R2", "retry phase kept", {6'b0, dt_phase}, 8'h03);

    // R1: reset in mid-grant clears acknowledge and phase
    drive(4'b0010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check("R5", "grant before reset", {4'b0, dack_n}, 8'h0D);
    rst = 1'b1;
    @(negedge clk);
    check("R1", "dack_n after reset", {4'b0, dack_n}, 8'h0F);
    check("R1", "phase after reset", {6'b0, dt_phase}, 8'h00);
    dreq = '0;
    #1;
    check("R1", "hold_n after reset", {7'b0, hold_n}, 8'h01);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule